// File: doc/BRIEF.md
# Smart Card Character Receiver with Parity Error Signalling

This block receives characters from a half-duplex smart card style serial line. The line idles high. A character is a low start bit, then eight data bits sent least significant bit first, then a parity bit, then one slot in which the receiver may answer on the same wire. When the parity check fails, the receiver pulls the shared line low during that slot. The sender reads this as a request to send the character again. A character that fails is never presented as received data.

Bit timing comes from an elementary time unit (etu). The etu is a number of clock cycles set on an input port. A falling edge on the idle line starts a character. Half an etu later the line is checked again, and the character is dropped if the line is no longer low. After that, each bit is sampled once at the middle of its etu. A good character loads the data register and raises data-ready. A bad character raises a sticky parity-error flag instead. Software clears data-ready with a read strobe and clears parity-error with a clear strobe. Two interrupt outputs follow the two flags, gated by a common enable.

Top module: `sc_char_rx`

## Requirements
- R1: Data bits are taken least significant bit first. Each bit is sampled once, at the middle of its etu, timed from a start bit that is still low half an etu after the falling edge. A good character appears on `rxData` with its first data bit at bit 0.
- R2: With `oddParity`=0, a character passes when the XOR of the eight data bits and the parity bit is 0. With `oddParity`=1, it passes when that XOR is 1.
- R3: A character that fails parity sets `parityErr` to 1. It leaves `dataReady` unchanged and leaves `rxData` holding its previous value.
- R4: A character that passes parity loads `rxData`, sets `dataReady` to 1 and leaves `parityErr` unchanged.
- R5: `rxIrq` is high while `dataReady` and `rxIntEn` are both 1. `errIrq` is high while `parityErr` and `rxIntEn` are both 1. Both are low when `rxIntEn` is 0.
- R6: For a failed character, `lineDriveLow` is 1 from 10.5 etu to 11.5 etu after the start edge, and 0 at every other time. For a passing character it stays 0 for the whole frame.
- R7: A one-cycle pulse on `rdStrobe` clears `dataReady` to 0.
- R8: A one-cycle pulse on `perClrStrobe` clears `parityErr` to 0. If it is not cleared, `parityErr` stays 1 through later good characters.
- R9: A low pulse shorter than half an etu on an idle line is ignored. No flag or data changes, and the receiver stays ready for the next start bit.
- R10: The receiver ignores the line until 12.5 etu after the start edge and accepts a new start edge from then on. A character sent again right after an error signal is received and checked like any new character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| lineIn | input | 1 | Line level, already synchronous to clk |
| etuLen | input | CNT_W | Clock cycles per etu (at least 4) |
| oddParity | input | 1 | 1 selects odd parity, 0 selects even parity |
| rxIntEn | input | 1 | Enable for both interrupt outputs |
| rdStrobe | input | 1 | Pulse that clears data-ready |
| perClrStrobe | input | 1 | Pulse that clears parity-error |
| lineDriveLow | output | 1 | 1 pulls the shared line low (open-drain enable) |
| rxData | output | 8 | Last character that passed parity |
| dataReady | output | 1 | Data-ready flag |
| parityErr | output | 1 | Sticky parity-error flag |
| rxIrq | output | 1 | Receive interrupt request |
| errIrq | output | 1 | Error interrupt request |

## Verification
The assertions assume the following about the inputs. `etuLen` is at least 4 and does not change while a character is in flight. Both strobes are single-cycle pulses. `perClrStrobe` is never pulsed while the error slot is being driven, so `parityErr` is still 1 whenever the line is pulled low. The bench meets these assumptions by construction. It fixes the etu before reset, issues strobes only between frames, and models the wire as the AND of its own transmit level and the inverse of `lineDriveLow`, so the receiver sees its own error signal on the wire.

// File: rtl/sc_rx_pkg.sv
package sc_rx_pkg;
  localparam int DATA_BITS = 8;

  // Strobes from control to datapath
  typedef struct packed {
    logic shiftEn;   // capture one data bit at mid-etu
    logic checkEn;   // parity bit at mid-etu: judge the character
  } rxStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_BITS,
    ST_WAIT,
    ST_SLOT,
    ST_GUARD
  } rxState_t;
endpackage

// File: rtl/sc_rx_ctrl.sv
module sc_rx_ctrl
  import sc_rx_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int NBITS = DATA_BITS
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineIn,
  input  logic [CNT_W-1:0] etuLen,
  input  logic             badChar,
  output rxStrobe_t        strobe,
  output logic             driveLow
);
  localparam int IDX_W = $clog2(NBITS + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBITS);

  rxState_t         state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] bitIdx;
  logic             lineQ;
  logic             etuHit;
  logic             halfHit;

  assign etuHit  = (cnt == etuLen);
  assign halfHit = (cnt == (etuLen >> 1));

  always_comb begin
    strobe.shiftEn = (state == ST_BITS) && etuHit && (bitIdx != LAST_IDX);
    strobe.checkEn = (state == ST_BITS) && etuHit && (bitIdx == LAST_IDX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      bitIdx   <= '0;
      lineQ    <= 1'b1;
      driveLow <= 1'b0;
    end else begin
      lineQ <= lineIn;
      unique case (state)
        ST_IDLE: begin
          if (lineQ && !lineIn) begin
            state <= ST_START;
            cnt   <= CNT_W'(1);
          end
        end
        ST_START: begin
          if (halfHit) begin
            cnt    <= CNT_W'(1);
            bitIdx <= '0;
            state  <= lineIn ? ST_IDLE : ST_BITS;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_BITS: begin
          if (etuHit) begin
            cnt <= CNT_W'(1);
            if (bitIdx == LAST_IDX) state <= ST_WAIT;
            else bitIdx <= bitIdx + IDX_W'(1);
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_WAIT: begin
          if (etuHit) begin
            cnt      <= CNT_W'(1);
            state    <= ST_SLOT;
            driveLow <= badChar;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_SLOT: begin
          if (etuHit) begin
            cnt      <= CNT_W'(1);
            state    <= ST_GUARD;
            driveLow <= 1'b0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_GUARD: begin
          if (etuHit) begin
            cnt   <= '0;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sc_rx_dp.sv
module sc_rx_dp
  import sc_rx_pkg::*;
#(
  parameter int NBITS = DATA_BITS
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineIn,
  input  rxStrobe_t        strobe,
  input  logic             oddParity,
  input  logic             rxIntEn,
  input  logic             rdStrobe,
  input  logic             perClrStrobe,
  output logic             badChar,
  output logic [NBITS-1:0] rxData,
  output logic             dataReady,
  output logic             parityErr,
  output logic             rxIrq,
  output logic             errIrq
);
  logic [NBITS-1:0] shiftReg;
  logic             parityOk;

  // lineIn carries the parity bit when checkEn is high
  assign parityOk = ((^shiftReg) ^ lineIn) == oddParity;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      rxData    <= '0;
      dataReady <= 1'b0;
      parityErr <= 1'b0;
      badChar   <= 1'b0;
    end else begin
      if (strobe.shiftEn) shiftReg <= {lineIn, shiftReg[NBITS-1:1]};

      if (rdStrobe) dataReady <= 1'b0;
      if (perClrStrobe) parityErr <= 1'b0;

      if (strobe.checkEn) begin
        badChar <= !parityOk;
        if (parityOk) begin
          rxData    <= shiftReg;
          dataReady <= 1'b1;
        end else begin
          parityErr <= 1'b1;
        end
      end
    end
  end

  assign rxIrq  = dataReady & rxIntEn;
  assign errIrq = parityErr & rxIntEn;
endmodule

// File: rtl/sc_char_rx.sv
module sc_char_rx
  import sc_rx_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 lineIn,
  input  logic [CNT_W-1:0]     etuLen,
  input  logic                 oddParity,
  input  logic                 rxIntEn,
  input  logic                 rdStrobe,
  input  logic                 perClrStrobe,
  output logic                 lineDriveLow,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 dataReady,
  output logic                 parityErr,
  output logic                 rxIrq,
  output logic                 errIrq
);
  rxStrobe_t strobe;
  logic      badChar;

  sc_rx_ctrl #(.CNT_W(CNT_W), .NBITS(DATA_BITS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .lineIn   (lineIn),
    .etuLen   (etuLen),
    .badChar  (badChar),
    .strobe   (strobe),
    .driveLow (lineDriveLow)
  );

  sc_rx_dp #(.NBITS(DATA_BITS)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .lineIn       (lineIn),
    .strobe       (strobe),
    .oddParity    (oddParity),
    .rxIntEn      (rxIntEn),
    .rdStrobe     (rdStrobe),
    .perClrStrobe (perClrStrobe),
    .badChar      (badChar),
    .rxData       (rxData),
    .dataReady    (dataReady),
    .parityErr    (parityErr),
    .rxIrq        (rxIrq),
    .errIrq       (errIrq)
  );
endmodule

// File: rtl/sc_char_rx_chk.sv
module sc_char_rx_chk (
  input logic       clk,
  input logic       rstN,
  input logic       rdStrobe,
  input logic       perClrStrobe,
  input logic       lineDriveLow,
  input logic [7:0] rxData,
  input logic       dataReady,
  input logic       parityErr
);
  AST_DATA_WITH_READY: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rxData) |-> dataReady);                                    // R4
  AST_ERR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    $rose(parityErr) |-> $stable(rxData));                              // R3
  AST_NO_DUAL_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataReady) |-> !$rose(parityErr));                            // R2
  AST_READY_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dataReady) |-> $past(rdStrobe));                              // R7
  AST_PER_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(parityErr) |-> $past(perClrStrobe));                          // R8
  AST_DRIVE_ON_ERR: assert property (@(posedge clk) disable iff (!rstN)
    lineDriveLow |-> parityErr);                                        // R6
endmodule

bind sc_char_rx sc_char_rx_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .rdStrobe     (rdStrobe),
  .perClrStrobe (perClrStrobe),
  .lineDriveLow (lineDriveLow),
  .rxData       (rxData),
  .dataReady    (dataReady),
  .parityErr    (parityErr)
);

// File: tb/sc_char_rx_tb.sv
`timescale 1ns/1ps
module sc_char_rx_tb;
  localparam int CNT_W = 12;
  localparam int ETU   = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busTx = 1'b1;
  logic lineIn;
  logic [CNT_W-1:0] etuLen = CNT_W'(ETU);
  logic oddSel = 1'b0;
  logic rxIntEn = 1'b1;
  logic rdStrobe = 1'b0;
  logic perClrStrobe = 1'b0;
  logic lineDriveLow;
  logic [7:0] rxData;
  logic dataReady, parityErr, rxIrq, errIrq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] expData = '0;
  logic       expReady = 1'b0;
  logic       expPer = 1'b0;

  always #2.5 clk = ~clk;

  // open-drain wire: bench transmitter AND receiver pull-down
  assign lineIn = busTx & ~lineDriveLow;

  sc_char_rx #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .etuLen(etuLen),
    .oddParity(oddSel), .rxIntEn(rxIntEn), .rdStrobe(rdStrobe),
    .perClrStrobe(perClrStrobe), .lineDriveLow(lineDriveLow),
    .rxData(rxData), .dataReady(dataReady), .parityErr(parityErr),
    .rxIrq(rxIrq), .errIrq(errIrq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic checkFlags(input string req);
    check({req, " rxData"}, 32'(rxData), 32'(expData));
    check({req, " dataReady"}, 32'(dataReady), 32'(expReady));
    check({req, " parityErr"}, 32'(parityErr), 32'(expPer));
    check({req, " R5 rxIrq"}, 32'(rxIrq), 32'(expReady & rxIntEn));
    check({req, " R5 errIrq"}, 32'(errIrq), 32'(expPer & rxIntEn));
  endtask

  // Sends one frame starting at a negedge and checks the error slot (R6).
  task automatic sendChar(input logic [7:0] d, input logic corrupt, input string req);
    logic p;
    p = oddSel ? ~^d : ^d;
    if (corrupt) p = ~p;
    busTx = 1'b0;
    repeat (ETU) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      busTx = d[i];
      repeat (ETU) @(negedge clk);
    end
    busTx = p;
    repeat (ETU) @(negedge clk);
    busTx = 1'b1;
    repeat (4) @(negedge clk);
    check({req, " R6 before slot"}, 32'(lineDriveLow), 32'(0));
    @(negedge clk);
    check({req, " R6 slot start"}, 32'(lineDriveLow), 32'(corrupt));
    repeat (7) @(negedge clk);
    check({req, " R6 slot end"}, 32'(lineDriveLow), 32'(corrupt));
    @(negedge clk);
    check({req, " R6 after slot"}, 32'(lineDriveLow), 32'(0));
    repeat (11) @(negedge clk);
    if (corrupt) expPer = 1'b1;
    else begin
      expData = d;
      expReady = 1'b1;
    end
    checkFlags(req);
  endtask

  task automatic pulseRead();
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
    expReady = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulsePerClr();
    perClrStrobe = 1'b1;
    @(negedge clk);
    perClrStrobe = 1'b0;
    expPer = 1'b0;
    @(negedge clk);
  endtask

  task automatic testReset();
    checkFlags("reset");
    check("reset R6 drive", 32'(lineDriveLow), 32'(0));
  endtask

  task automatic testGoodEven();
    sendChar(8'hA5, 1'b0, "R1 R4 good even A5");
    sendChar(8'h01, 1'b0, "R1 R2 good even 01");
  endtask

  task automatic testRead();
    pulseRead();
    checkFlags("R7 read clears");
  endtask

  task automatic testBadThenRetry();
    sendChar(8'h3C, 1'b1, "R3 bad parity");
    sendChar(8'h3C, 1'b0, "R10 retransfer");
    pulseRead();
    pulsePerClr();
    checkFlags("R8 clear strobe");
  endtask

  task automatic testSticky();
    sendChar(8'h77, 1'b1, "R3 bad again");
    sendChar(8'h12, 1'b0, "R8 sticky over good");
    pulsePerClr();
    pulseRead();
    checkFlags("R8 sticky cleared");
  endtask

  task automatic testOdd();
    oddSel = 1'b1;
    sendChar(8'hC3, 1'b0, "R2 odd good");
    sendChar(8'h5A, 1'b1, "R2 odd bad");
    pulsePerClr();
    pulseRead();
    oddSel = 1'b0;
  endtask

  task automatic testNoIrq();
    rxIntEn = 1'b0;
    sendChar(8'hE1, 1'b1, "R5 masked err");
    sendChar(8'h9E, 1'b0, "R5 masked rx");
    rxIntEn = 1'b1;
    @(negedge clk);
    checkFlags("R5 unmasked");
    pulsePerClr();
    pulseRead();
  endtask

  task automatic testGlitch();
    busTx = 1'b0;
    repeat (2) @(negedge clk);
    busTx = 1'b1;
    repeat (ETU * 2) @(negedge clk);
    checkFlags("R9 glitch ignored");
    sendChar(8'h6B, 1'b0, "R9 after glitch");
    pulseRead();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    testReset();
    testGoodEven();
    testRead();
    testBadThenRetry();
    testSticky();
    testOdd();
    testNoIrq();
    testGlitch();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule